// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This sequencer performs the hardware side of exception entry inside a small processor core. Once the core accepts an exception, the block rounds the active stack pointer down to an 8-byte boundary. It then stores an eight-word context frame below that boundary through a word-wide memory port with a request/ready handshake. After the last store it reads the handler address from a vector table based at address zero. It finishes by handing the new stack pointer, the link value and the program counter back to the core in a single cycle.

A reset-caused entry takes a shorter path. Nothing is stored. Table word zero is read and sent to the main stack pointer, then the reset vector is read and sent to the program counter. After any entry a blocking flag stays high until the core reports that the handler's first instruction has begun, and no further exception is accepted while the flag is high.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, busy, done, mem_req, late_block and all register write strobes are low.
- R2: A non-reset entry issues exactly eight writes, at descending addresses base+28, base+24, down to base+0. The data order is: status word, return address, LR, R12, R3, R2, R1, R0. R0 sits at the lowest address.
- R3: base equals sp_in with bits [2:0] cleared, minus 32. sp_we presents base on sp_wdata.
- R4: The stored status word equals xpsr_in with bit 9 replaced by sp_in bit 2, taken before alignment.
- R5: On a non-reset entry, exactly one read is issued, at byte address exc_num*4, and only after all eight writes have been accepted.
- R6: With is_reset high, no write occurs. The block reads address 0 and then exc_num*4. msp_we presents the word read from address 0, and sp_we and lr_we stay low.
- R7: On a non-reset entry, lr_we presents exc_ret_in unchanged on lr_wdata.
- R8: done, pc_we and the other write strobes pulse for one cycle together. pc_wdata carries the vector word that was read, and busy is low in the following cycle.
- R9: late_block rises in the cycle after done and stays high until first_insn is seen. A start that arrives while busy or late_block is high is ignored.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Exception accepted, begin entry |
| is_reset | input | 1 | Entry cause is reset |
| exc_num | input | EXC_W | Exception number |
| sp_in | input | 32 | Active stack pointer |
| xpsr_in | input | 32 | Status word |
| ret_addr_in | input | 32 | Return address |
| lr_in | input | 32 | Link register |
| r12_in | input | 32 | R12 |
| r3_in | input | 32 | R3 |
| r2_in | input | 32 | R2 |
| r1_in | input | 32 | R1 |
| r0_in | input | 32 | R0 |
| exc_ret_in | input | 32 | Exception-return code chosen by the core |
| first_insn | input | 1 | Handler's first instruction started |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| sp_we | output | 1 | Load active stack pointer |
| sp_wdata | output | 32 | New active stack pointer |
| msp_we | output | 1 | Load main stack pointer |
| msp_wdata | output | 32 | New main stack pointer |
| lr_we | output | 1 | Load link register |
| lr_wdata | output | 32 | New link value |
| pc_we | output | 1 | Load program counter |
| pc_wdata | output | 32 | Handler address |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Entry complete |
| late_block | output | 1 | Late arrivals blocked |

## Verification
The checks assume three things about the core. It holds the register inputs, sp_in, exc_ret_in and is_reset steady from start until done. It raises first_insn only after done. The memory returns read data in the same cycle as mem_ready.

The bench follows these rules. It changes inputs only before start and after done. It raises first_insn only while late_block is high. It computes mem_rdata directly from mem_addr. It sweeps every exception number with both values of stack bit 2, runs each entry with a free-flowing memory and with a stalling one, and adds reset entries.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int ALIGN_BIT   = 9;
  localparam int FRAME_BYTES = FRAME_WORDS * 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH,
    S_RMSP,
    S_RVEC,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/exc_frame_mux.sv
module exc_frame_mux
  import exc_entry_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic              sp_bit2,
  input  logic [WORD_W-1:0] xpsr,
  input  logic [WORD_W-1:0] ret_addr,
  input  logic [WORD_W-1:0] lr,
  input  logic [WORD_W-1:0] r12,
  input  logic [WORD_W-1:0] r3,
  input  logic [WORD_W-1:0] r2,
  input  logic [WORD_W-1:0] r1,
  input  logic [WORD_W-1:0] r0,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] slot [FRAME_WORDS];
  logic [WORD_W-1:0] xpsr_tagged;

  always_comb begin
    xpsr_tagged            = xpsr;
    xpsr_tagged[ALIGN_BIT] = sp_bit2;
  end

  // slot 0 is the lowest address
  assign slot[0] = r0;
  assign slot[1] = r1;
  assign slot[2] = r2;
  assign slot[3] = r3;
  assign slot[4] = r12;
  assign slot[5] = lr;
  assign slot[6] = ret_addr;
  assign slot[7] = xpsr_tagged;

  assign word = slot[idx];
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_entry_pkg::*;
#(
  parameter int EXC_W = 6
) (
  input  seq_state_e        state,
  input  logic [WORD_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [EXC_W-1:0]  exc,
  output logic [WORD_W-1:0] addr
);
  localparam int PAD_I = WORD_W - IDX_W - 2;
  localparam int PAD_E = WORD_W - EXC_W - 2;

  always_comb begin
    case (state)
      S_PUSH:  addr = base + {{PAD_I{1'b0}}, idx, 2'b00};
      S_RVEC:  addr = {{PAD_E{1'b0}}, exc, 2'b00};
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/exc_late_guard.sv
module exc_late_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic block_o
);
  logic block_d;

  always_comb begin
    block_d = block_o;
    if (set_i)      block_d = 1'b1;
    else if (clr_i) block_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) block_o <= 1'b0;
    else        block_o <= block_d;
  end

  // R9
  late_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> block_o);
  // R9
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_o && !clr_i && !set_i |=> block_o);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int EXC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_reset,
  input  logic [EXC_W-1:0]  exc_num,
  input  logic [31:0]       sp_in,
  input  logic [31:0]       xpsr_in,
  input  logic [31:0]       ret_addr_in,
  input  logic [31:0]       lr_in,
  input  logic [31:0]       r12_in,
  input  logic [31:0]       r3_in,
  input  logic [31:0]       r2_in,
  input  logic [31:0]       r1_in,
  input  logic [31:0]       r0_in,
  input  logic [31:0]       exc_ret_in,
  input  logic              first_insn,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              sp_we,
  output logic [31:0]       sp_wdata,
  output logic              msp_we,
  output logic [31:0]       msp_wdata,
  output logic              lr_we,
  output logic [31:0]       lr_wdata,
  output logic              pc_we,
  output logic [31:0]       pc_wdata,
  output logic              busy,
  output logic              done,
  output logic              late_block
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(FRAME_WORDS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              cause_q, sp2_q;
  logic [WORD_W-1:0] base_q, msp_q, vec_q;
  logic [EXC_W-1:0]  exc_q;
  logic              cap_start, cap_msp, cap_vec, hs;

  assign hs = mem_req && mem_ready;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cap_start = 1'b0;
    cap_msp   = 1'b0;
    cap_vec   = 1'b0;
    case (state_q)
      S_IDLE: if (start && !late_block) begin
        cap_start = 1'b1;
        idx_d     = IDX_TOP;
        state_d   = is_reset ? S_RMSP : S_PUSH;
      end
      S_PUSH: if (hs) begin
        if (idx_q == '0) state_d = S_RVEC;
        else             idx_d   = idx_q - 1'b1;
      end
      S_RMSP: if (hs) begin
        cap_msp = 1'b1;
        state_d = S_RVEC;
      end
      S_RVEC: if (hs) begin
        cap_vec = 1'b1;
        state_d = S_FIN;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_start) begin
      cause_q <= is_reset;
      sp2_q   <= sp_in[2];
      exc_q   <= exc_num;
      base_q  <= {sp_in[WORD_W-1:3], 3'b000} - WORD_W'(FRAME_BYTES);
    end
    if (cap_msp) msp_q <= mem_rdata;
    if (cap_vec) vec_q <= mem_rdata;
  end

  exc_frame_mux u_mux (
    .idx(idx_q), .sp_bit2(sp2_q), .xpsr(xpsr_in), .ret_addr(ret_addr_in),
    .lr(lr_in), .r12(r12_in), .r3(r3_in), .r2(r2_in), .r1(r1_in),
    .r0(r0_in), .word(mem_wdata)
  );

  exc_addr_gen #(.EXC_W(EXC_W)) u_addr (
    .state(state_q), .base(base_q), .idx(idx_q), .exc(exc_q), .addr(mem_addr)
  );

  exc_late_guard u_late (
    .clk(clk), .rst_n(rst_sync_n), .set_i(done), .clr_i(first_insn),
    .block_o(late_block)
  );

  assign mem_req   = (state_q == S_PUSH) || (state_q == S_RMSP) || (state_q == S_RVEC);
  assign mem_we    = (state_q == S_PUSH);
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign pc_we     = done;
  assign pc_wdata  = vec_q;
  assign lr_we     = done && !cause_q;
  assign lr_wdata  = exc_ret_in;
  assign sp_we     = done && !cause_q;
  assign sp_wdata  = base_q;
  assign msp_we    = done && cause_q;
  assign msp_wdata = msp_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));
  // R2
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we && hs && (idx_q != '0) |=> mem_we && (mem_addr == $past(mem_addr) - 32'd4));
  // R5
  vec_after_push_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we && hs && (idx_q == '0) |=> mem_req && !mem_we
      && (mem_addr == {{(WORD_W-EXC_W-2){1'b0}}, exc_q, 2'b00}));
  // R6
  reset_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy && cause_q |-> !mem_we && !sp_we && !lr_we);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done && !busy);
  // R3
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sp_we |-> (sp_wdata[2:0] == 3'b000));
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam int CLK_P = 10;
  localparam int EW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_reset = 1'b0, first_insn = 1'b0, mem_ready = 1'b0;
  logic [EW-1:0] exc_num = '0;
  logic [31:0] sp_in = '0, xpsr_in = '0, ret_addr_in = '0, lr_in = '0, r12_in = '0;
  logic [31:0] r3_in = '0, r2_in = '0, r1_in = '0, r0_in = '0, exc_ret_in = '0;
  logic [31:0] mem_rdata;
  logic mem_req, mem_we, sp_we, msp_we, lr_we, pc_we, busy, done, late_block;
  logic [31:0] mem_addr, mem_wdata, sp_wdata, msp_wdata, lr_wdata, pc_wdata;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] vec_fn(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A00_0001;
  endfunction

  assign mem_rdata = vec_fn(mem_addr);

  exc_entry_seq #(.EXC_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_reset(is_reset), .exc_num(exc_num),
    .sp_in(sp_in), .xpsr_in(xpsr_in), .ret_addr_in(ret_addr_in), .lr_in(lr_in),
    .r12_in(r12_in), .r3_in(r3_in), .r2_in(r2_in), .r1_in(r1_in), .r0_in(r0_in),
    .exc_ret_in(exc_ret_in), .first_insn(first_insn), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .msp_we(msp_we),
    .msp_wdata(msp_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .busy(busy), .done(done), .late_block(late_block)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx);
    logic [31:0] x;
    case (idx)
      0: return r0_in;
      1: return r1_in;
      2: return r2_in;
      3: return r3_in;
      4: return r12_in;
      5: return lr_in;
      6: return ret_addr_in;
      default: begin
        x = xpsr_in;
        x[9] = sp_in[2];
        return x;
      end
    endcase
  endfunction

  task automatic run_entry(input int exc, input logic rcause, input logic [31:0] sp,
                           input int stall);
    logic [31:0] base, prev_addr;
    logic stalled_prev;
    int nw, nr, cyc;
    exc_num     = EW'(exc);
    sp_in       = sp;
    xpsr_in     = 32'h6100_0000 | {22'd0, ~sp[2], 9'd0} | 32'(exc);
    ret_addr_in = 32'h0000_4000 + 32'(exc * 6);
    lr_in       = 32'h0000_5001 + 32'(exc);
    r12_in      = 32'hC000_0000 + 32'(exc);
    r3_in       = 32'h3333_0000 + 32'(exc);
    r2_in       = 32'h2222_0000 + 32'(exc);
    r1_in       = 32'h1111_0000 + 32'(exc);
    r0_in       = 32'h0F0F_0000 + 32'(exc);
    exc_ret_in  = 32'hFFFF_FFF0 | 32'(exc & 15);
    base = {sp[31:3], 3'b000} - 32'd32;
    @(negedge clk);
    start = 1'b1;
    is_reset = rcause;
    @(negedge clk);
    start = 1'b0;
    nw = 0; nr = 0; cyc = 0; stalled_prev = 1'b0; prev_addr = '0;
    forever begin
      mem_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      if (stalled_prev) chk("R10 held address", mem_addr, prev_addr);
      stalled_prev = mem_req && !mem_ready;
      prev_addr = mem_addr;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          if (rcause) chk("R6 no write on reset", 32'(mem_we), 32'd0);
          chk("R2 write address", mem_addr, base + 32'(4 * (7 - nw)));
          chk(nw == 0 ? "R4 status word" : "R2 frame word", mem_wdata, exp_word(7 - nw));
          nw++;
        end else begin
          if (rcause && nr == 0) chk("R6 stack entry read", mem_addr, 32'd0);
          else begin
            chk("R5 vector address", mem_addr, 32'(exc * 4));
            if (!rcause) chk("R5 writes before read", 32'(nw), 32'd8);
          end
          nr++;
        end
      end
      if (done) break;
      cyc++;
      if (cyc > 200) begin
        chk("R8 entry completes", 32'd0, 32'd1);
        break;
      end
      @(negedge clk);
    end
    chk("R8 pc strobe", 32'(pc_we), 32'd1);
    chk("R8 pc value", pc_wdata, vec_fn(32'(exc * 4)));
    if (!rcause) begin
      chk("R2 write count", 32'(nw), 32'd8);
      chk("R7 lr strobe", 32'(lr_we), 32'd1);
      chk("R7 lr value", lr_wdata, exc_ret_in);
      chk("R3 sp strobe", 32'(sp_we), 32'd1);
      chk("R3 sp value", sp_wdata, base);
      chk("R6 no msp load", 32'(msp_we), 32'd0);
    end else begin
      chk("R6 write count", 32'(nw), 32'd0);
      chk("R6 msp strobe", 32'(msp_we), 32'd1);
      chk("R6 msp value", msp_wdata, vec_fn(32'd0));
      chk("R6 sp untouched", 32'(sp_we), 32'd0);
      chk("R6 lr untouched", 32'(lr_we), 32'd0);
    end
    mem_ready = 1'b0;
    is_reset = 1'b0;
    @(negedge clk);
    chk("R8 busy drops", 32'(busy), 32'd0);
    chk("R8 done single", 32'(done), 32'd0);
    chk("R9 late set", 32'(late_block), 32'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 start ignored busy", 32'(busy), 32'd0);
    chk("R9 start ignored req", 32'(mem_req), 32'd0);
    chk("R9 late held", 32'(late_block), 32'd1);
    first_insn = 1'b1;
    @(negedge clk);
    first_insn = 1'b0;
    chk("R9 late cleared", 32'(late_block), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 late_block", 32'(late_block), 32'd0);
    chk("R1 strobes", {28'd0, sp_we, msp_we, lr_we, pc_we}, 32'd0);
    for (int e = 0; e < (1 << EW); e++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 2; s++)
          run_entry(e, 1'b0, 32'h2000_0800 + 32'(e * 64) + (b != 0 ? 32'd4 : 32'd0), s);
    for (int e = 1; e < 4; e++)
      for (int s = 0; s < 2; s++)
        run_entry(e, 1'b1, 32'h0000_0000, s);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule